// File: doc/BRIEF.md
# Transition-Interval Serial Frame Transmitter

This block sends one command frame over a single wire in which information lives in the time between line edges rather than in the line level. A short gap between two consecutive toggles stands for a 0. A gap twice as long stands for a 1. The line rests high. When a frame starts, the line is pulled low, and that first edge carries no bit. Every later edge closes one bit. Because each frame has an odd number of bits, the total number of edges is even, so the line always finishes high. This also keeps the line from staying low for long.

A requester presents a layout code, a write flag, a request/response flag, an address word, a 25-bit payload and a unit period counted in clock cycles. The transfer happens on a valid/ready handshake. The block then builds the frame, which holds the sync pattern, the command, the address, either the payload or a dummy bit, and a 5-bit checksum. It plays the frame out MSB first, holds a busy flag while it does so, and pulses a done flag when the line is back high.

Top module: `gap_frame_tx`

## Requirements
- R1: While reset is held and directly after it, lineOut is 1, busy is 0, reqReady is 1 and done is 0.
- R2: The falling edge of lineOut that opens a frame happens on the clock edge that accepts the request. After it, a 0 bit is a gap of exactly U cycles between toggles and a 1 bit is a gap of exactly 2U cycles. U is the unit period, at least 2.
- R3: Every frame starts with the sync bits 0 then 1, followed by the command. reqLayout 0 (plug-addressed) sends 1,0,W. reqLayout 1 (memory access) sends 0,1,X,W, where X is reqResp. reqLayout 2 or 3 (broadcast) sends 1,1,W. W is reqWrite, and 1 means write.
- R4: The address follows the command, MSB first. Layout 0 sends reqAddr[7:0] (plug number in [7:4], message number in [3:0]). Layout 1 sends reqAddr[14:0] (plug number in [14:11], memory word in [10:0]). The broadcast layouts send reqAddr[19:0] (a 16-bit plug mask in [19:4], message number in [3:0]).
- R5: A write then sends reqPayload[24:0] MSB first. A read sends one 0 dummy bit instead. Frames are therefore 19/43, 27/51 or 31/55 bits long (read/write) for layouts 0, 1 and broadcast.
- R6: The last 5 bits are a checksum, sent MSB first. It uses generator x^5+x^3+x^2+x+1, starts from zero, and covers every bit from the first sync bit through the payload or dummy bit.
- R7: The final toggle of a frame returns lineOut to 1. On that same edge busy falls and done rises for exactly one cycle. While busy is 0, lineOut is 1.
- R8: A request is accepted only when reqValid and reqReady are both 1. reqReady is 0 while a frame is in flight. A request held valid during a frame has no effect and starts no further frame.
- R9: The unit period is captured at acceptance. Changes on unitCycles during a frame do not alter that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqLayout | input | 2 | Frame layout selector |
| reqWrite | input | 1 | 1 = write (payload sent), 0 = read (dummy bit) |
| reqResp | input | 1 | Request/response flag for the memory layout |
| reqAddr | input | 20 | Address word, lower bits used per layout |
| reqPayload | input | 25 | Write payload |
| unitCycles | input | UNIT_W | Unit period in clock cycles (at least 2) |
| lineOut | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The bench builds the block with UNIT_W set to 4. This makes 15 the largest unit period, so the doubled 30-cycle gap reaches the top of the gap counter, while the smallest unit of 2 exercises the tightest edge spacing. With gaps this short, dozens of full-length 55-bit frames fit in a short run. Every layout, both directions, the request/response flag and the spare broadcast code are all reached. The bench also changes the period during a frame and holds a request valid while the block is busy.

// File: rtl/gap_tx_pkg.sv
package gap_tx_pkg;
  localparam int SYNC_W      = 2;
  localparam int CMD_MAX     = 4;
  localparam int PLUG_ADDR_W = 8;
  localparam int MEM_ADDR_W  = 15;
  localparam int BCAST_ADDR_W = 20;
  localparam int PAY_W       = 25;
  localparam int CRC_W       = 5;
  localparam int BODY_MAX    = SYNC_W + CMD_MAX + BCAST_ADDR_W + PAY_W;
  localparam int FRAME_MAX   = BODY_MAX + CRC_W;
  localparam int LEN_W       = $clog2(FRAME_MAX + 1);
  localparam logic [CRC_W-1:0] CRC_POLY = 5'b01111;

  typedef enum logic [1:0] {
    LAY_PLUG  = 2'd0,
    LAY_MEM   = 2'd1,
    LAY_BCAST = 2'd2,
    LAY_SPARE = 2'd3
  } layout_e;

  typedef struct packed {
    logic load;
    logic toggle;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/gap_tx_dp.sv
module gap_tx_dp
  import gap_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [1:0]       reqLayout,
  input  logic             reqWrite,
  input  logic             reqResp,
  input  logic [19:0]      reqAddr,
  input  logic [PAY_W-1:0] reqPayload,
  output logic [LEN_W-1:0] frameLen,
  output logic             nextBit,
  output logic             lineOut
);
  logic [BODY_MAX-1:0]  hdr, body;
  logic [LEN_W-1:0]     hdrLen, bodyLen;
  logic [CRC_W-1:0]     crcVal;
  logic [FRAME_MAX-1:0] frameRaw, frameAl, shiftQ;

  // unrolled checksum over the right-aligned body; the top valid bit goes in first
  function automatic logic [CRC_W-1:0] crcOver(input logic [BODY_MAX-1:0] bits,
                                               input logic [LEN_W-1:0] n);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = BODY_MAX - 1; i >= 0; i--) begin
      if (i < int'(n)) begin
        fb = bits[i] ^ c[CRC_W-1];
        c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end
    end
    return c;
  endfunction

  always_comb begin
    case (layout_e'(reqLayout))
      LAY_PLUG: begin
        hdr    = BODY_MAX'({2'b01, 2'b10, reqWrite, reqAddr[PLUG_ADDR_W-1:0]});
        hdrLen = LEN_W'(SYNC_W + 3 + PLUG_ADDR_W);
      end
      LAY_MEM: begin
        hdr    = BODY_MAX'({2'b01, 2'b01, reqResp, reqWrite, reqAddr[MEM_ADDR_W-1:0]});
        hdrLen = LEN_W'(SYNC_W + 4 + MEM_ADDR_W);
      end
      default: begin
        hdr    = BODY_MAX'({2'b01, 2'b11, reqWrite, reqAddr[BCAST_ADDR_W-1:0]});
        hdrLen = LEN_W'(SYNC_W + 3 + BCAST_ADDR_W);
      end
    endcase
    if (reqWrite) begin
      body    = (hdr << PAY_W) | BODY_MAX'(reqPayload);
      bodyLen = hdrLen + LEN_W'(PAY_W);
    end else begin
      body    = hdr << 1;          // dummy zero keeps the bit count odd
      bodyLen = hdrLen + LEN_W'(1);
    end
    crcVal   = crcOver(body, bodyLen);
    frameRaw = {body, crcVal};
    frameLen = bodyLen + LEN_W'(CRC_W);
    frameAl  = frameRaw << (FRAME_MAX - int'(frameLen));
  end

  assign nextBit = shiftQ[FRAME_MAX-2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      lineOut <= 1'b1;
    end else if (stb.load) begin
      shiftQ  <= frameAl;
      lineOut <= 1'b0;
    end else if (stb.toggle) begin
      shiftQ  <= shiftQ << 1;
      lineOut <= ~lineOut;
    end
  end
endmodule

// File: rtl/gap_tx_ctrl.sv
module gap_tx_ctrl
  import gap_tx_pkg::*;
#(
  parameter int UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [UNIT_W-1:0] unitCycles,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              nextBit,
  output logic              reqReady,
  output logic              busy,
  output logic              done,
  output strobe_t           stb
);
  localparam int CNT_W = UNIT_W + 1;

  logic              running;
  logic [UNIT_W-1:0] unitQ;
  logic [CNT_W-1:0]  gapCnt;
  logic [LEN_W-1:0]  bitsLeft;
  logic              gapEnd;

  assign reqReady   = !running;
  assign busy       = running;
  assign gapEnd     = running && (gapCnt == '0);
  assign stb.load   = reqValid && !running;
  assign stb.toggle = gapEnd;
  assign stb.finish = gapEnd && (bitsLeft == LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      unitQ    <= '0;
      gapCnt   <= '0;
      bitsLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.load) begin
        running  <= 1'b1;
        unitQ    <= unitCycles;
        // the first frame bit is always the sync zero: one unit
        gapCnt   <= {1'b0, unitCycles} - CNT_W'(1);
        bitsLeft <= frameLen;
      end else if (running) begin
        if (gapCnt != '0) begin
          gapCnt <= gapCnt - CNT_W'(1);
        end else begin
          bitsLeft <= bitsLeft - LEN_W'(1);
          if (stb.finish) running <= 1'b0;
          else gapCnt <= (nextBit ? {unitQ, 1'b0} : {1'b0, unitQ}) - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/gap_frame_tx.sv
module gap_frame_tx
  import gap_tx_pkg::*;
#(
  parameter int UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqLayout,
  input  logic              reqWrite,
  input  logic              reqResp,
  input  logic [19:0]       reqAddr,
  input  logic [24:0]       reqPayload,
  input  logic [UNIT_W-1:0] unitCycles,
  output logic              lineOut,
  output logic              busy,
  output logic              done
);
  strobe_t          stb;
  logic [LEN_W-1:0] frameLen;
  logic             nextBit;

  gap_tx_ctrl #(.UNIT_W(UNIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .unitCycles(unitCycles),
    .frameLen(frameLen), .nextBit(nextBit), .reqReady(reqReady),
    .busy(busy), .done(done), .stb(stb)
  );

  gap_tx_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqLayout(reqLayout),
    .reqWrite(reqWrite), .reqResp(reqResp), .reqAddr(reqAddr),
    .reqPayload(reqPayload), .frameLen(frameLen), .nextBit(nextBit),
    .lineOut(lineOut)
  );
endmodule

// File: rtl/gap_tx_checker.sv
module gap_tx_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic lineOut,
  input logic busy,
  input logic done
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> lineOut); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R7
  AST_START_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $fell(lineOut)); // R2
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$stable(lineOut)) |=> $stable(lineOut)); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy); // R8
endmodule

bind gap_frame_tx gap_tx_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .lineOut(lineOut), .busy(busy), .done(done)
);

// File: tb/test_gap_frame_tx.sv
module test_gap_frame_tx;
  localparam int UW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqLayout = '0;
  logic          reqWrite = 1'b0;
  logic          reqResp = 1'b0;
  logic [19:0]   reqAddr = '0;
  logic [24:0]   reqPayload = '0;
  logic [UW-1:0] unitCycles = UW'(2);
  logic          lineOut, busy, done;

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  int ntog = 0;
  int tt [0:63];
  logic prevLine = 1'b1;
  logic [0:63] expB;
  int expLen, cmdEnd, addrEnd, bodyEnd;

  gap_frame_tx #(.UNIT_W(UW)) i_gap_frame_tx (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLayout(reqLayout), .reqWrite(reqWrite), .reqResp(reqResp),
    .reqAddr(reqAddr), .reqPayload(reqPayload), .unitCycles(unitCycles),
    .lineOut(lineOut), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (lineOut !== prevLine) begin
        if (ntog < 64) tt[ntog] = cyc;
        ntog++;
      end
      prevLine = lineOut;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exv);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exv);
    end
  endtask

  task automatic pushBits(input logic [63:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      expB[expLen] = v[i];
      expLen++;
    end
  endtask

  function automatic logic [63:0] rangeVal(input logic [0:63] v, input int lo, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r = {r[62:0], v[lo + i]};
    return r;
  endfunction

  task automatic buildExp(input int lay, input bit w, input bit rs,
                          input logic [19:0] a, input logic [24:0] p);
    logic [4:0] c;
    logic fb;
    expLen = 0;
    expB = '0;
    pushBits(64'b01, 2);
    if (lay == 0) begin
      pushBits({61'b0, 2'b10, w}, 3); cmdEnd = expLen; pushBits(64'(a[7:0]), 8);
    end else if (lay == 1) begin
      pushBits({60'b0, 2'b01, rs, w}, 4); cmdEnd = expLen; pushBits(64'(a[14:0]), 15);
    end else begin
      pushBits({61'b0, 2'b11, w}, 3); cmdEnd = expLen; pushBits(64'(a), 20);
    end
    addrEnd = expLen;
    if (w) pushBits(64'(p), 25); else pushBits(64'b0, 1);
    bodyEnd = expLen;
    c = '0;
    for (int i = 0; i < bodyEnd; i++) begin
      fb = expB[i] ^ c[4];
      c = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'b01111;
    end
    pushBits(64'(c), 5);
  endtask

  task automatic runFrame(input int lay, input bit w, input bit rs, input logic [19:0] a,
                          input logic [24:0] p, input int u, input bit disturb, input bit hold);
    int acc, guard, d;
    bit timeOk;
    logic [0:63] g;
    buildExp(lay, w, rs, a, p);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    ntog = 0;
    reqLayout = 2'(lay); reqWrite = w; reqResp = rs; reqAddr = a; reqPayload = p;
    unitCycles = UW'(u); reqValid = 1'b1;
    @(negedge clk);
    acc = cyc;
    chk(busy && !reqReady, "R8 busy and not ready after accept", {busy, reqReady}, 2'b10);
    if (hold) begin
      reqAddr = ~a; reqLayout = 2'(lay) ^ 2'b01; reqWrite = !w;
    end else reqValid = 1'b0;
    if (disturb) unitCycles = (u == 2) ? UW'(9) : UW'(2);
    guard = 0;
    while (!done && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (hold && guard == 3) reqValid = 1'b0;
    end
    chk(done, "R7 done pulse seen", 64'(done), 1);
    chk(lineOut && !busy, "R7 line high and idle at done", {lineOut, busy}, 2'b10);
    @(negedge clk);
    chk(!done, "R7 done lasts one cycle", 64'(done), 0);
    repeat (5) @(negedge clk);
    chk(ntog == expLen + 1, hold ? "R8 held request starts nothing" : "R5 toggle count",
        64'(ntog), 64'(expLen + 1));
    chk(tt[0] == acc, "R2 opening edge at accept", 64'(tt[0]), 64'(acc));
    timeOk = 1'b1;
    g = '0;
    for (int i = 1; i < ntog && i < 64; i++) begin
      d = tt[i] - tt[i-1];
      if (d == u) g[i-1] = 1'b0;
      else if (d == 2 * u) g[i-1] = 1'b1;
      else timeOk = 1'b0;
    end
    chk(timeOk, disturb ? "R9 gaps keep captured unit" : "R2 gaps are U or 2U", 64'(timeOk), 1);
    chk(rangeVal(g, 0, cmdEnd) == rangeVal(expB, 0, cmdEnd), "R3 sync and command",
        rangeVal(g, 0, cmdEnd), rangeVal(expB, 0, cmdEnd));
    chk(rangeVal(g, cmdEnd, addrEnd - cmdEnd) == rangeVal(expB, cmdEnd, addrEnd - cmdEnd),
        "R4 address field", rangeVal(g, cmdEnd, addrEnd - cmdEnd), rangeVal(expB, cmdEnd, addrEnd - cmdEnd));
    chk(rangeVal(g, addrEnd, bodyEnd - addrEnd) == rangeVal(expB, addrEnd, bodyEnd - addrEnd),
        "R5 payload or dummy", rangeVal(g, addrEnd, bodyEnd - addrEnd), rangeVal(expB, addrEnd, bodyEnd - addrEnd));
    chk(rangeVal(g, bodyEnd, 5) == rangeVal(expB, bodyEnd, 5), "R6 checksum",
        rangeVal(g, bodyEnd, 5), rangeVal(expB, bodyEnd, 5));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    nChecks++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(lineOut && !busy && reqReady && !done, "R1 state in reset",
        {lineOut, busy, reqReady, done}, 4'b1010);
    rstN = 1'b1;
    @(negedge clk);
    chk(lineOut && !busy && reqReady && !done, "R1 state after reset",
        {lineOut, busy, reqReady, done}, 4'b1010);
    // directed corners
    runFrame(0, 0, 0, 20'h000A5, 25'h0, 2, 0, 0);
    runFrame(0, 1, 0, 20'hFFFFF, 25'h1FFFFFF, 2, 0, 0);
    runFrame(1, 0, 1, 20'h7FFFF, 25'h0, 15, 0, 0);
    runFrame(1, 1, 0, 20'h12345, 25'h0ABCDEF, 3, 0, 0);
    runFrame(2, 1, 0, 20'hA5A5A, 25'h1555555, 15, 0, 0);
    runFrame(3, 0, 0, 20'h0F0F3, 25'h0, 4, 0, 0);
    runFrame(1, 1, 1, 20'h00000, 25'h0000000, 2, 0, 0);
    runFrame(2, 0, 0, 20'h13579, 25'h0, 5, 1, 0);
    runFrame(0, 1, 0, 20'h0003C, 25'h0F0F0F0, 2, 1, 0);
    runFrame(1, 0, 0, 20'h04321, 25'h0, 6, 0, 1);
    // random mix
    for (int k = 0; k < 40; k++) begin
      runFrame(int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2),
               20'($urandom), 25'($urandom), 2 + int'($urandom % 14), 0, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule